// File: doc/BRIEF.md
# Single-Cycle 16-Bit Processor Core

This block is a compact processor that completes one 16-bit instruction on every rising clock edge. It contains a sixteen-entry register file of 16-bit words, an arithmetic/logic unit, a program counter with next-address logic, and a control decoder. The instruction memory and the data memory sit outside the core. The core presents the program counter as the instruction fetch address and takes the fetched word back on the same cycle. The data port carries an address, write data and a write strobe, and its read data returns combinationally.

Each instruction word holds a 4-bit opcode in bits 15:12. The remaining 12 bits are laid out in one of three ways:
- Register form: destination in 11:8, first source in 7:4, second source in 3:0.
- Immediate form: a register in 11:8 and an 8-bit immediate in 7:0.
- Jump form: a 12-bit immediate in 11:0.

Both immediates are two's-complement values and are sign-extended to 16 bits. Program addresses count in words. Register 0 always reads as zero.

Top module: `sc16_core`

## Requirements
- R1: A synchronous active-high `rst` sets `imem_addr` to 0 at the next rising edge and holds it there while asserted; no data-memory write occurs during reset.
- R2: Every instruction that does not redirect control (including a branch whose condition fails) advances `imem_addr` by exactly one.
- R3: Register-form opcodes write rd in the same cycle. Opcode 0000 writes rs+rt, 0001 writes rs-rt, 0100 writes rs AND rt, 0101 writes rs OR rt, and 0110 writes the bitwise inverse of rs, with rt ignored.
- R4: Opcode 1000 adds the sign-extended 8-bit immediate to rd in place, so an immediate of 0xFF subtracts one.
- R5: Opcode 1001 replaces bits 15:8 of rd with the 8-bit immediate and keeps bits 7:0 of rd.
- R6: Opcodes 0010 (load) and 0011 (store) put rs+rt, modulo 2^16, on `dmem_addr`. A load writes `dmem_rdata` into rd. A store drives rd's value on `dmem_wdata` with `dmem_we` high for that cycle. No other opcode raises `dmem_we`.
- R7: Opcode 1010 branches when rd is zero, and opcode 1011 branches when rd is nonzero. A taken branch sets the PC to PC plus the sign-extended 8-bit immediate; a branch that is not taken falls through to PC+1. Backward offsets work.
- R8: Opcode 1111 sets the PC to PC plus the sign-extended 12-bit immediate, in either direction.
- R9: Opcode 1101 writes PC+1 into register 1 regardless of its rd field, and sets the PC to PC plus the sign-extended 8-bit immediate.
- R10: Opcode 1110 sets the PC to the value held in rd.
- R11: Register 0 reads as zero; any write aimed at it is discarded.
- R12: Opcodes 0111 and 1100 change no register and no memory and only advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Instruction fetch address (the PC) |
| imem_data | input | 16 | Instruction word fetched from `imem_addr` |
| dmem_addr | output | 16 | Data-memory word address (rs+rt) |
| dmem_wdata | output | 16 | Store data (value of rd) |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_rdata | input | 16 | Combinational load data for `dmem_addr` |

## Verification
The core runs one program built inside the bench. That program dumps registers through stores to an incrementing address, so every store is a scoreboard item with a known address and value.

The arithmetic operands are chosen so that each operation gives a different result from the same sources. A carry-out sum, a borrowing subtraction and a masked AND/OR pair therefore separate adder, subtractor and logic faults. An immediate of 0xFF separates sign extension from zero extension.

Each control transfer is paired with a skipped instruction that would change a marker register. Both the taken and the not-taken case of each branch kind are run. A backward loop and a backward jump separate correct offset handling from a path that hangs or wanders.

A load from a base of 0xFFFF plus 2 tells wrapping address arithmetic apart from other address forms. Writes aimed at register 0, and the two spare opcodes encoded with live-looking fields, are checked by dumping the registers they might have touched.

// File: rtl/sc16_pkg.sv
package sc16_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned REG_N   = 16;
  localparam int unsigned REG_AW  = $clog2(REG_N);
  localparam int unsigned IMM_S_W = 8;
  localparam int unsigned IMM_L_W = 12;
  localparam int unsigned LINK_REG = 1;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_LW   = 4'h2, OP_SW   = 4'h3,
    OP_AND  = 4'h4, OP_OR   = 4'h5, OP_NOT  = 4'h6, OP_SPR7 = 4'h7,
    OP_ADDI = 4'h8, OP_LDHI = 4'h9, OP_BZ   = 4'hA, OP_BNZ  = 4'hB,
    OP_SPRC = 4'hC, OP_JAL  = 4'hD, OP_JR   = 4'hE, OP_J    = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {WB_ALU, WB_MEM, WB_LINK, WB_ADDI, WB_LDHI} wb_sel_e;
  typedef enum logic [2:0] {NPC_SEQ, NPC_BZ, NPC_BNZ, NPC_REL8, NPC_REL12, NPC_REG} npc_sel_e;

  typedef struct packed {
    opcode_e              op;
    logic [REG_AW-1:0]    rd;
    logic [REG_AW-1:0]    rs;
    logic [REG_AW-1:0]    rt;
    logic [IMM_S_W-1:0]   imm8;
    logic [IMM_L_W-1:0]   imm12;
    logic                 wb_en;
    logic                 link;
    wb_sel_e              wb_sel;
    npc_sel_e             npc_sel;
    logic                 mem_we;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] sext8(input logic [IMM_S_W-1:0] v);
    return {{(WORD_W-IMM_S_W){v[IMM_S_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] sext12(input logic [IMM_L_W-1:0] v);
    return {{(WORD_W-IMM_L_W){v[IMM_L_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] alu_calc(input opcode_e op,
                                                 input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    case (op)
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_NOT:  return ~a;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] high_merge(input logic [IMM_S_W-1:0] imm,
                                                   input logic [WORD_W-1:0] old);
    return {imm, old[WORD_W-IMM_S_W-1:0]};
  endfunction
endpackage

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned W    = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c
);
  // entry 0 has no storage: it is a constant zero
  logic [W-1:0] regs [1:NREG-1];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a);
    if (a == '0) return '0;
    return regs[a];
  endfunction

  assign rd_a = rd_port(ra_a);
  assign rd_b = rd_port(ra_b);
  assign rd_c = rd_port(ra_c);
endmodule

// File: rtl/sc16_decode.sv
module sc16_decode
  import sc16_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  always_comb begin
    ctrl.op      = opcode_e'(instr[15:12]);
    ctrl.rd      = instr[11:8];
    ctrl.rs      = instr[7:4];
    ctrl.rt      = instr[3:0];
    ctrl.imm8    = instr[7:0];
    ctrl.imm12   = instr[11:0];
    ctrl.wb_en   = 1'b0;
    ctrl.link    = 1'b0;
    ctrl.wb_sel  = WB_ALU;
    ctrl.npc_sel = NPC_SEQ;
    ctrl.mem_we  = 1'b0;
    unique case (ctrl.op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT: ctrl.wb_en = 1'b1;
      OP_LW:   begin ctrl.wb_en = 1'b1; ctrl.wb_sel = WB_MEM;  end
      OP_SW:   ctrl.mem_we = 1'b1;
      OP_ADDI: begin ctrl.wb_en = 1'b1; ctrl.wb_sel = WB_ADDI; end
      OP_LDHI: begin ctrl.wb_en = 1'b1; ctrl.wb_sel = WB_LDHI; end
      OP_BZ:   ctrl.npc_sel = NPC_BZ;
      OP_BNZ:  ctrl.npc_sel = NPC_BNZ;
      OP_JAL:  begin
        ctrl.wb_en   = 1'b1;
        ctrl.link    = 1'b1;
        ctrl.wb_sel  = WB_LINK;
        ctrl.npc_sel = NPC_REL8;
      end
      OP_JR:   ctrl.npc_sel = NPC_REG;
      OP_J:    ctrl.npc_sel = NPC_REL12;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc16_next_pc.sv
module sc16_next_pc
  import sc16_pkg::*;
(
  input  logic [WORD_W-1:0]  pc,
  input  npc_sel_e           sel,
  input  logic [WORD_W-1:0]  rd_val,
  input  logic [IMM_S_W-1:0] imm8,
  input  logic [IMM_L_W-1:0] imm12,
  output logic [WORD_W-1:0]  pc_seq,
  output logic               redirect,
  output logic [WORD_W-1:0]  pc_next
);
  logic rd_zero;

  assign pc_seq  = pc + WORD_W'(1);
  assign rd_zero = (rd_val == '0);

  always_comb begin
    unique case (sel)
      NPC_BZ:    redirect = rd_zero;
      NPC_BNZ:   redirect = !rd_zero;
      NPC_REL8, NPC_REL12, NPC_REG: redirect = 1'b1;
      default:   redirect = 1'b0;
    endcase
  end

  always_comb begin
    if (!redirect)              pc_next = pc_seq;
    else if (sel == NPC_REG)    pc_next = rd_val;
    else if (sel == NPC_REL12)  pc_next = pc + sext12(imm12);
    else                        pc_next = pc + sext8(imm8);
  end
endmodule

// File: rtl/sc16_core.sv
module sc16_core
  import sc16_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  output logic [WORD_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic [WORD_W-1:0]  dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [WORD_W-1:0]  dmem_rdata
);
  ctrl_t               ctrl;
  logic [WORD_W-1:0]   pc_q, pc_seq, pc_next;
  logic                redirect;
  logic [WORD_W-1:0]   rs_val, rt_val, rd_val;
  logic [WORD_W-1:0]   alu_y;
  logic                wb_en;
  logic [REG_AW-1:0]   wb_addr;
  logic [WORD_W-1:0]   wb_data;

  sc16_decode dec_i (.instr(imem_data), .ctrl(ctrl));

  sc16_regfile #(.NREG(REG_N), .W(WORD_W)) rf_i (
    .clk(clk), .we(wb_en), .waddr(wb_addr), .wdata(wb_data),
    .ra_a(ctrl.rs), .ra_b(ctrl.rt), .ra_c(ctrl.rd),
    .rd_a(rs_val), .rd_b(rt_val), .rd_c(rd_val)
  );

  sc16_next_pc npc_i (
    .pc(pc_q), .sel(ctrl.npc_sel), .rd_val(rd_val),
    .imm8(ctrl.imm8), .imm12(ctrl.imm12),
    .pc_seq(pc_seq), .redirect(redirect), .pc_next(pc_next)
  );

  assign alu_y = alu_calc(ctrl.op, rs_val, rt_val);

  always_comb begin
    unique case (ctrl.wb_sel)
      WB_MEM:  wb_data = dmem_rdata;
      WB_LINK: wb_data = pc_seq;
      WB_ADDI: wb_data = rd_val + sext8(ctrl.imm8);
      WB_LDHI: wb_data = high_merge(ctrl.imm8, rd_val);
      default: wb_data = alu_y;
    endcase
  end

  assign wb_en   = ctrl.wb_en && !rst;
  assign wb_addr = ctrl.link ? REG_AW'(LINK_REG) : ctrl.rd;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rd_val;
  assign dmem_we    = ctrl.mem_we && !rst;
endmodule

// File: rtl/sc16_core_chk.sv
module sc16_core_chk
  import sc16_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [WORD_W-1:0]  imem_addr,
  input logic [INSTR_W-1:0] imem_data,
  input logic               dmem_we,
  input logic [WORD_W-1:0]  rd_val,
  input logic               wb_en,
  input logic [REG_AW-1:0]  wb_addr,
  input logic [WORD_W-1:0]  wb_data
);
  opcode_e op;
  logic    falls_through, br_taken;

  assign op = opcode_e'(imem_data[15:12]);
  assign falls_through = (op inside {OP_ADD, OP_SUB, OP_LW, OP_SW, OP_AND, OP_OR,
                                     OP_NOT, OP_SPR7, OP_ADDI, OP_LDHI, OP_SPRC})
                      || (op == OP_BZ && rd_val != '0)
                      || (op == OP_BNZ && rd_val == '0);
  assign br_taken = (op == OP_BZ && rd_val == '0) || (op == OP_BNZ && rd_val != '0);

  AST_PC_RESET: assert property (@(posedge clk) rst |=> imem_addr == '0); // R1
  AST_NO_WE_IN_RESET: assert property (@(posedge clk) rst |-> !dmem_we); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    falls_through |=> imem_addr == $past(imem_addr) + WORD_W'(1)); // R2
  AST_WE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == OP_SW); // R6
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> imem_addr == $past(imem_addr + sext8(imem_data[7:0]))); // R7
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    op == OP_J |=> imem_addr == $past(imem_addr + sext12(imem_data[11:0]))); // R8
  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (rst)
    op == OP_JAL |-> wb_en && wb_addr == REG_AW'(LINK_REG)
                     && wb_data == imem_addr + WORD_W'(1)); // R9
  AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
    op == OP_JR |=> imem_addr == $past(rd_val)); // R10
endmodule

bind sc16_core sc16_core_chk chk_i (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .rd_val(rd_val), .wb_en(wb_en), .wb_addr(wb_addr),
  .wb_data(wb_data)
);

// File: tb/sc16_core_tb_top.sv
module sc16_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [15:0] imem [0:255];
  logic [15:0] dmem [0:255];

  int n_chk = 0;
  int n_bad = 0;
  int pw = 0;
  int st_addr = 0;
  logic [31:0] q_ad [$];
  string       q_tag [$];
  logic [31:0] mon_exp;
  string       mon_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc16_core dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;

  function automatic logic [15:0] enc_r(int op, int rd, int rs, int rt);
    return {op[3:0], rd[3:0], rs[3:0], rt[3:0]};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rd, int imm);
    return {op[3:0], rd[3:0], imm[7:0]};
  endfunction
  function automatic logic [15:0] enc_j(int op, int imm);
    return {op[3:0], imm[11:0]};
  endfunction

  task automatic emit(input logic [15:0] w);
    imem[pw] = w;
    pw++;
  endtask

  task automatic push_exp(input int addr, input logic [15:0] v, input string tag);
    q_ad.push_back({addr[15:0], v});
    q_tag.push_back(tag);
  endtask

  // driver: dump register r with a store to address r14, then bump r14
  task automatic expect_reg(input int r, input logic [15:0] v, input string tag);
    emit(enc_r(3, r, 0, 14));
    emit(enc_i(8, 14, 1));
    push_exp(st_addr, v, tag);
    st_addr++;
  endtask

  task automatic clr(input int r);
    emit(enc_r(0, r, 0, 0));
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build_program();
    int a_jal, p_jr, t_jr;
    for (int i = 0; i < 256; i++) begin imem[i] = 16'hF000; dmem[i] = 16'h0000; end
    clr(14);
    clr(1);  emit(enc_i(8, 1, 10));                          expect_reg(1, 16'h000A, "R4");
    clr(2);  emit(enc_i(8, 2, 8'h34)); emit(enc_i(9, 2, 8'h12)); expect_reg(2, 16'h1234, "R5");
    clr(3);  emit(enc_i(8, 3, 8'hFF));                       expect_reg(3, 16'hFFFF, "R4");
    emit(enc_r(0, 4, 2, 3));                                 expect_reg(4, 16'h1233, "R3");
    emit(enc_r(1, 5, 2, 1));                                 expect_reg(5, 16'h122A, "R3");
    clr(7);  emit(enc_i(9, 7, 8'h0F));
    emit(enc_r(4, 6, 2, 7));                                 expect_reg(6, 16'h0200, "R3");
    emit(enc_r(5, 8, 2, 7));                                 expect_reg(8, 16'h1F34, "R3");
    emit(enc_r(6, 9, 2, 3));                                 expect_reg(9, 16'hEDCB, "R3");
    emit(enc_i(8, 0, 5)); emit(enc_r(0, 0, 2, 2));           expect_reg(0, 16'h0000, "R11");
    // load from 0xFFFF + 2 = word 1 (holds 0x1234), then store there via rs+rt
    clr(11); emit(enc_i(8, 11, 8'hFF));
    clr(12); emit(enc_i(8, 12, 2));
    emit(enc_r(2, 10, 11, 12));                              expect_reg(10, 16'h1234, "R6");
    emit(enc_r(3, 4, 11, 12)); push_exp(1, 16'h1233, "R6");
    clr(13);
    emit(enc_i(10, 0, 2));  emit(enc_i(8, 13, 1));           expect_reg(13, 16'h0000, "R7");
    emit(enc_i(10, 1, 2));  emit(enc_i(8, 13, 2));           expect_reg(13, 16'h0002, "R7");
    emit(enc_i(11, 1, 2));  emit(enc_i(8, 13, 4));           expect_reg(13, 16'h0002, "R7");
    emit(enc_i(11, 0, 2));  emit(enc_i(8, 13, 8));           expect_reg(13, 16'h000A, "R2");
    clr(15); clr(12); emit(enc_i(8, 12, 3));
    emit(enc_i(8, 15, 1)); emit(enc_i(8, 12, 8'hFF)); emit(enc_i(11, 12, 8'hFE));
    expect_reg(15, 16'h0003, "R7");
    a_jal = pw;
    emit(enc_i(13, 5, 3)); emit(enc_i(8, 13, 16)); emit(enc_i(8, 13, 32));
    expect_reg(1, 16'(a_jal + 1), "R9");
    expect_reg(13, 16'h000A, "R9");
    p_jr = pw; t_jr = p_jr + 4;
    clr(7); emit(enc_i(8, 7, t_jr)); emit(enc_r(14, 7, 0, 0)); emit(enc_i(8, 13, 64));
    expect_reg(13, 16'h000A, "R10");
    emit(enc_j(15, 2)); emit(enc_i(8, 13, 1));
    emit(enc_j(15, 2)); emit(enc_j(15, 2)); emit(enc_j(15, 12'hFFF));
    expect_reg(13, 16'h000A, "R8");
    emit(16'h7DDD); emit(16'hC111);
    expect_reg(13, 16'h000A, "R12");
    expect_reg(1, 16'(a_jal + 1), "R12");
    emit(enc_j(15, 0));
  endtask

  // monitor: each store must match the next scoreboard item
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      n_chk++;
      if (q_ad.size() == 0) begin
        n_bad++;
        $display("FAIL R6: unexpected store actual=%h/%h expected=none", dmem_addr, dmem_wdata);
      end else begin
        mon_exp = q_ad.pop_front();
        mon_tag = q_tag.pop_front();
        if ({dmem_addr, dmem_wdata} !== mon_exp) begin
          n_bad++;
          $display("FAIL %s: store addr/data actual=%h/%h expected=%h/%h",
                   mon_tag, dmem_addr, dmem_wdata, mon_exp[31:16], mon_exp[15:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    build_program();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imem_addr, 16'h0000);
    rst = 1'b0;
    cyc = 0;
    while (q_ad.size() != 0 && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (q_ad.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s: pending stores actual=%0d expected=0", q_tag[0], q_ad.size());
    end
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run reset pc", imem_addr, 16'h0000);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule